// File: doc/BRIEF.md
# Serial Port FIFO Controller with Flow Control

This block sits between a processor and the bit-level engine of a serial port. It holds a 16-entry byte queue in each direction. The processor pushes bytes into the transmit queue, and the serializer pops them one at a time. The deserializer pushes received bytes into the receive queue, and the processor pops them.

A sticky transmit-low-water flag tells software when to refill the transmit queue. The fill level that raises the flag comes from a 2-bit threshold selector. Each queue has its own level-sensitive flush control. A modem-control enable decides whether the clear-to-send input and the request-to-send output take part in flow control.

Baud generation, the shift registers and interrupt routing live elsewhere. Clock-synchronous operation expects software to leave the modem-control enable at 0.

Top module: `uart_fifo_ctl`

## Requirements
- R1: The transmit queue stores up to 16 bytes in first-in first-out order. `tx_level` reports its occupancy. `tx_valid` is 1 when the queue is non-empty and sending is allowed, and `tx_rdata` then shows the oldest byte. A pop with `tx_valid` = 1 removes that byte at the clock edge.
- R2: The receive queue follows the same rules. It is filled by `rx_push`, read through `rx_rdata`/`rx_valid`, and emptied by `rx_pop`. `rx_level` reports its occupancy.
- R3: A push into a full queue is discarded, and the matching `tx_ovf`/`rx_ovf` output is 1 in that same cycle. A pop while the valid output is 0 changes nothing.
- R4: Control bits `cfg_wdata[1:0]` select the low-water threshold: 00 selects 8 bytes, 01 selects 4, 10 selects 2 and 11 selects 0. At each clock edge where the visible `tx_level` is at or below the threshold, `txe_flag` is set for the following cycle.
- R5: `txe_flag` is sticky. A status write with `stat_wbit` = 0 clears it at that edge, unless the R4 condition holds in the same cycle, in which case it stays 1. A status write with `stat_wbit` = 1 has no effect.
- R6: While control bit `cfg_wdata[3]` (transmit flush) is held at 1, the transmit queue reads as empty: `tx_level` = 0 and `tx_valid` = 0. Pushes are discarded without overflow. Bytes stored before the flush never reappear.
- R7: Control bit `cfg_wdata[4]` (receive flush) acts on the receive queue in the same way.
- R8: When control bit `cfg_wdata[2]` (modem-control enable) is 0, `cts_n` is ignored and `rts_n` is 0.
- R9: When the modem-control enable is 1, `tx_valid` is 0 while `cts_n` is 1. `rts_n` is 1 exactly while the receive queue holds 16 bytes.
- R10: After reset both queues are empty, all control bits are 0, `txe_flag` is 1 and `rts_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 5 | Control value: [1:0] threshold, [2] modem enable, [3] transmit flush, [4] receive flush |
| stat_we | input | 1 | Write strobe for the status flag |
| stat_wbit | input | 1 | Value written to the flag (0 clears it) |
| tx_push | input | 1 | Processor pushes a transmit byte |
| tx_wdata | input | 8 | Transmit byte |
| tx_ovf | output | 1 | Transmit push dropped because the queue is full |
| tx_pop | input | 1 | Serializer takes a byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | A transmit byte may be taken |
| rx_push | input | 1 | Deserializer pushes a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_ovf | output | 1 | Receive push dropped because the queue is full |
| rx_pop | input | 1 | Processor takes a received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_valid | output | 1 | A received byte is available |
| tx_level | output | 5 | Transmit occupancy |
| rx_level | output | 5 | Receive occupancy |
| txe_flag | output | 1 | Sticky transmit low-water flag |
| cts_n | input | 1 | Clear-to-send pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |

## Verification
The valid, data, overflow, level and `rts_n` outputs are combinational on the registered state, so each result of an edge shows up directly after that edge. The bench drives inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge. It compares them with a queue model that is advanced once per rising edge. `txe_flag` lags the level it watches by one edge, and a control write takes effect from the cycle after its edge. The model updates the flag and applies control writes only after checking the cycle's outputs, so each check compares against the value due in that exact cycle.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [4:0]                   cfg_wdata,
  input  logic                         stat_we,
  input  logic                         stat_wbit,
  input  logic                         tx_push,
  input  logic [DW-1:0]                tx_wdata,
  output logic                         tx_ovf,
  input  logic                         tx_pop,
  output logic [DW-1:0]                tx_rdata,
  output logic                         tx_valid,
  input  logic                         rx_push,
  input  logic [DW-1:0]                rx_wdata,
  output logic                         rx_ovf,
  input  logic                         rx_pop,
  output logic [DW-1:0]                rx_rdata,
  output logic                         rx_valid,
  output logic [$clog2(DEPTH+1)-1:0]   tx_level,
  output logic [$clog2(DEPTH+1)-1:0]   rx_level,
  output logic                         txe_flag,
  input  logic                         cts_n,
  output logic                         rts_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [1:0] thr_sel;
  logic       mdm_en, tx_flush, rx_flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_sel  <= '0;
      mdm_en   <= 1'b0;
      tx_flush <= 1'b0;
      rx_flush <= 1'b0;
    end else if (cfg_we) begin
      thr_sel  <= cfg_wdata[1:0];
      mdm_en   <= cfg_wdata[2];
      tx_flush <= cfg_wdata[3];
      rx_flush <= cfg_wdata[4];
    end
  end

  // transmit queue
  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_wr, tx_rd, cts_ok;

  assign cts_ok   = !mdm_en || !cts_n;
  assign tx_level = tx_flush ? '0 : tx_cnt;
  assign tx_full  = (tx_cnt == FULL);
  assign tx_valid = (tx_level != '0) && cts_ok;
  assign tx_rdata = tx_mem[tx_rp];
  assign tx_ovf   = tx_push && !tx_flush && tx_full;
  assign tx_wr    = tx_push && !tx_flush && !tx_full;
  assign tx_rd    = tx_pop && tx_valid;

  always_ff @(posedge clk)
    if (tx_wr) tx_mem[tx_wp] <= tx_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n || tx_flush) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_wr) tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_rd) tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_wr) - CW'(tx_rd);
    end
  end

  // receive queue
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_full, rx_wr, rx_rd;

  assign rx_level = rx_flush ? '0 : rx_cnt;
  assign rx_full  = (rx_cnt == FULL);
  assign rx_valid = (rx_level != '0);
  assign rx_rdata = rx_mem[rx_rp];
  assign rx_ovf   = rx_push && !rx_flush && rx_full;
  assign rx_wr    = rx_push && !rx_flush && !rx_full;
  assign rx_rd    = rx_pop && rx_valid;

  always_ff @(posedge clk)
    if (rx_wr) rx_mem[rx_wp] <= rx_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n || rx_flush) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_wr) rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (rx_rd) rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_wr) - CW'(rx_rd);
    end
  end

  assign rts_n = mdm_en && (rx_level == FULL);

  // low-water flag
  logic [CW-1:0] thr;
  logic          low;
  always_comb thr = (thr_sel == 2'b11) ? '0 : CW'((DEPTH/2) >> thr_sel);
  assign low = (tx_level <= thr);

  always_ff @(posedge clk) begin
    if (!rst_n) txe_flag <= 1'b1;
    else        txe_flag <= (txe_flag && !(stat_we && !stat_wbit)) || low;
  end

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL && rx_cnt <= FULL);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !tx_pop) |=> (tx_cnt == $past(tx_cnt)));
  p_tx_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_cnt == '0));
  p_rx_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_cnt == '0));
  p_cts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdm_en && cts_n && !tx_flush) |=> (tx_cnt >= $past(tx_cnt)));
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    low |=> txe_flag);
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (txe_flag && !(stat_we && !stat_wbit)) |=> txe_flag);
endmodule

// File: tb/tb_uart_fifo_ctl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, stat_we = 0, stat_wbit = 0;
  logic [4:0] cfg_wdata = '0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, cts_n = 0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0;
  logic tx_ovf, tx_valid, rx_ovf, rx_valid, txe_flag, rts_n;
  logic [7:0] tx_rdata, rx_rdata;
  logic [4:0] tx_level, rx_level;

  always #2 clk = ~clk;

  uart_fifo_ctl dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mtx[$], mrx[$];
  logic [4:0] mctl = '0;
  bit mflag = 1;

  function automatic int thr_of(input logic [1:0] s);
    case (s) 2'd0: return 8; 2'd1: return 4; 2'd2: return 2; default: return 0; endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit pt, input logic [7:0] dt, input bit qt,
                     input bit pr, input logic [7:0] dr, input bit qr,
                     input bit cts, input bit cwe, input logic [4:0] cd,
                     input bit swe, input bit sb);
    bit mdm, tvalid, rvalid, eovf;
    int tl, rl;
    @(negedge clk);
    tx_push = pt; tx_wdata = dt; tx_pop = qt;
    rx_push = pr; rx_wdata = dr; rx_pop = qr; cts_n = cts;
    cfg_we = cwe; cfg_wdata = cd; stat_we = swe; stat_wbit = sb;
    #1;
    mdm = mctl[2];
    tl = mtx.size(); rl = mrx.size();
    tvalid = (tl > 0) && (!mdm || !cts);
    rvalid = rl > 0;
    chk(tx_level == tl, mctl[3] ? "R6 tx_level" : "R1 tx_level", tx_level, tl);
    chk(rx_level == rl, mctl[4] ? "R7 rx_level" : "R2 rx_level", rx_level, rl);
    chk(tx_valid == tvalid, mdm ? "R9 tx_valid" : "R1,R8 tx_valid", tx_valid, tvalid);
    chk(rx_valid == rvalid, "R2 rx_valid", rx_valid, rvalid);
    if (tvalid) chk(tx_rdata == mtx[0], "R1 tx_rdata", tx_rdata, mtx[0]);
    if (rvalid) chk(rx_rdata == mrx[0], "R2 rx_rdata", rx_rdata, mrx[0]);
    eovf = pt && !mctl[3] && tl == 16;
    chk(tx_ovf == eovf, "R3 tx_ovf", tx_ovf, eovf);
    eovf = pr && !mctl[4] && rl == 16;
    chk(rx_ovf == eovf, "R3 rx_ovf", rx_ovf, eovf);
    chk(rts_n == (mdm && rl == 16), mdm ? "R9 rts_n" : "R8 rts_n", rts_n, mdm && rl == 16);
    chk(txe_flag == mflag, "R4,R5 txe_flag", txe_flag, mflag);
    // model update for the coming edge
    mflag = (mflag && !(swe && !sb)) || (tl <= thr_of(mctl[1:0]));
    if (qt && tvalid) void'(mtx.pop_front());
    if (pt && !mctl[3] && tl < 16) mtx.push_back(dt);
    if (qr && rvalid) void'(mrx.pop_front());
    if (pr && !mctl[4] && rl < 16) mrx.push_back(dr);
    if (cwe) mctl = cd;
    if (mctl[3]) mtx.delete();
    if (mctl[4]) mrx.delete();
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, v, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R10: reset state
    chk(tx_level == 0 && rx_level == 0, "R10 levels", tx_level, 0);
    chk(txe_flag == 1, "R10 flag", txe_flag, 1);
    chk(rts_n == 0, "R10 rts_n", rts_n, 0);
    idle(2);
    // R1/R3: fill transmit queue beyond capacity
    for (int i = 0; i < 17; i++) cyc(1, 8'(i + 8'h30), 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: clear attempts with 1 (no effect) and 0
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle(1);
    // R4: drain at each threshold
    for (int i = 0; i < 9; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    wr_ctl(5'b00011);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R9: modem on, receive fill to full, cts blocking
    wr_ctl(5'b00101);
    for (int i = 0; i < 6; i++) cyc(1, 8'(i), 0, 0, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 17; i++) cyc(0, 0, 1, 1, 8'(i + 8'h80), 0, i[0], 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    // R8: modem off ignores cts
    wr_ctl(5'b00000);
    cyc(1, 8'h55, 1, 1, 8'h66, 0, 1, 0, 0, 0, 0);
    // R6: transmit flush held, pushes ignored
    wr_ctl(5'b01000);
    for (int i = 0; i < 3; i++) cyc(1, 8'hAA, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    wr_ctl(5'b00000);
    cyc(1, 8'h11, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: receive flush
    wr_ctl(5'b10000);
    cyc(0, 0, 0, 1, 8'hBB, 1, 0, 0, 0, 0, 0);
    wr_ctl(5'b00000);
    idle(2);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [4:0] c;
      c = 5'($urandom);
      c[3] = ($urandom % 6) == 0;
      c[4] = ($urandom % 6) == 0;
      cyc($urandom % 3 != 0, 8'($urandom), $urandom % 3 == 0,
          $urandom % 3 != 0, 8'($urandom), $urandom % 3 == 0,
          $urandom % 4 == 0, $urandom % 50 == 0, c,
          $urandom % 10 == 0, 1'($urandom));
    end
    finish_run();
  end
endmodule